// File: doc/BRIEF.md
# Retirement-Stage Result Checker

This block sits between a speculative execution core and the architected register file. Each instruction the core wants to retire arrives as one request. The request carries an opcode, two source register numbers, a destination register number, the two operand values the core used, and the result the core produced. The checker tests each request in two ways, side by side:

- It executes the operation again on the operands the core supplied and compares that value with the core's result.
- It reads the two sources from its own copy of the architected registers and compares them with the operands the core claims it read.

A result enters the register file only when the operands are confirmed. A bad result is replaced by the checker's own value. Any disagreement raises a fault flag and asks for a core restart.

The register file is read one cycle before it is written. A dependent instruction that directly follows its producer therefore takes the producer's value from a forwarding path. A progress watchdog requests a restart when no instruction has committed for a set number of cycles.

Top module: `retire_checker`

## Requirements
- R1: After a synchronous active-low reset, every output is 0 and every architected register holds 0.
- R2: The opcode selects the operation: 0 add, 1 subtract (a minus b), 2 and, 3 or, 4 xor, 5 load constant (the result is operand b, and source b is not checked). Codes 6 and 7 recompute to 0. The outputs for a request sampled at clock edge k appear after edge k+1 and last one cycle.
- R3: When both checks pass, `commit` is 1, `commit_dst` and `commit_data` give the destination and the core's result, and the register takes that value.
- R4: When a checked operand differs from the architected value of its source, `fault_opnd` and `restart_req` are 1, `commit` is 0, and no register changes.
- R5: When the operands match but the result does not, `commit`, `fault_calc` and `restart_req` are 1, and the recomputed value is committed and written.
- R6: An instruction that reads the destination of the instruction issued one cycle before it sees the value that instruction committed. If that instruction did not commit, it sees the older value.
- R7: Register 0 always reads 0. A commit to register 0 is reported but changes nothing.
- R8: When 256 consecutive clock edges pass without a commit, `restart_req` pulses for one cycle. The count starts over on every commit and after each pulse.
- R9: A request with both a bad operand and a bad result reports only `fault_opnd`.
- R10: Without a request, `commit`, `fault_calc` and `fault_opnd` stay 0. While `commit` is 0, `commit_dst` and `commit_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rt_valid | input | 1 | Retire request present this cycle |
| rt_op | input | 3 | Operation code |
| rt_src_a | input | 4 | First source register number |
| rt_src_b | input | 4 | Second source register number |
| rt_dst | input | 4 | Destination register number |
| rt_opnd_a | input | 32 | First operand value used by the core |
| rt_opnd_b | input | 32 | Second operand value (constant for load constant) |
| rt_result | input | 32 | Result produced by the core |
| commit | output | 1 | A result was written to architected state |
| commit_dst | output | 4 | Destination of the commit |
| commit_data | output | 32 | Value committed |
| fault_calc | output | 1 | Result mismatch detected and corrected |
| fault_opnd | output | 1 | Operand mismatch detected; instruction dropped |
| restart_req | output | 1 | Core restart request |

## Verification
A corrupted architected register cannot be read out directly. It shows up when a later instruction names that register as a source: the correct operands the bench supplies are then reported as `fault_opnd`, two edges after that request. A broken forwarding path shows up the same way, but only on back-to-back dependent pairs, so those pairs are issued on purpose after normal, corrected and dropped producers. An off-by-one watchdog count moves the `restart_req` pulse by one cycle. The bench catches this because it compares every output on every cycle against its own cycle model.

// File: rtl/rc_pkg.sv
// Package: shared opcode encoding for the retirement checker.
// Assumes a 3-bit opcode field; codes not listed here recompute to zero.
package rc_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_LDC = 3'd5
    } rc_op_e;
endpackage

// File: rtl/rc_alu.sv
// Module: rc_alu - independent recomputation unit of the checker.
// Does: produces the result of the requested operation from two operands.
// Assumes: purely combinational; unknown codes yield zero.
module rc_alu #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    import rc_pkg::*;

    // Purpose: select the arithmetic or logic function by opcode.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_LDC:  y = b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rc_regfile.sv
// Module: rc_regfile - architected register copy owned by the checker.
// Does: two combinational read ports, one synchronous write port.
// Assumes: entry 0 is hard-wired to zero; synchronous active-low reset clears all.
module rc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_entry
            if (gi == 0) begin : g_zero
                // Purpose: entry zero is a constant and ignores writes.
                assign regs[gi] = '0;
            end else begin : g_store
                // Purpose: hold one architected register value.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[gi] <= '0;
                    else if (we && (waddr == AW'(gi)))
                        regs[gi] <= wdata;
                end
            end
        end
    endgenerate

    // Purpose: read both sources without delay.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end
endmodule

// File: rtl/rc_watchdog.sv
// Module: rc_watchdog - forward-progress timer.
// Does: raises expire for one cycle when LIMIT edges pass without a kick.
// Assumes: kick and expiry both restart the count from zero.
module rc_watchdog #(
    parameter int LIMIT = 256,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expire
);
    logic [CW-1:0] cnt;

    // Purpose: detect the final idle cycle of the window.
    assign expire = !kick && (cnt == CW'(LIMIT - 1));

    // Purpose: count idle edges and start over on kick or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (kick || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/retire_checker.sv
// Module: retire_checker - commit-stage checker between core and architected state.
// Does: stage 0 captures the request and reads architected operands (with forwarding
//       from stage 1); stage 1 compares operands and result, writes the register file
//       and registers the outputs. A watchdog requests restart when commits stall.
// Assumes: one request per cycle at most; no memory operations; no flush handling here.
module retire_checker #(
    parameter int XLEN     = 32,
    parameter int NREG     = 16,
    parameter int WD_LIMIT = 256,
    localparam int AW      = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rt_valid,
    input  logic [2:0]      rt_op,
    input  logic [AW-1:0]   rt_src_a,
    input  logic [AW-1:0]   rt_src_b,
    input  logic [AW-1:0]   rt_dst,
    input  logic [XLEN-1:0] rt_opnd_a,
    input  logic [XLEN-1:0] rt_opnd_b,
    input  logic [XLEN-1:0] rt_result,
    output logic            commit,
    output logic [AW-1:0]   commit_dst,
    output logic [XLEN-1:0] commit_data,
    output logic            fault_calc,
    output logic            fault_opnd,
    output logic            restart_req
);
    import rc_pkg::*;

    // Stage 1 registers
    logic            s1_valid;
    logic [2:0]      s1_op;
    logic [AW-1:0]   s1_dst;
    logic [XLEN-1:0] s1_opa, s1_opb, s1_res;
    logic [XLEN-1:0] s1_arch_a, s1_arch_b;

    // Stage 0 / stage 1 combinational signals
    logic [XLEN-1:0] rf_a, rf_b, arch_a, arch_b;
    logic [XLEN-1:0] recomp, s1_data;
    logic            a_ok, b_ok, opnd_ok, calc_ok;
    logic            s1_commit, s1_fc, s1_fo, wd_expire;

    rc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (s1_commit),
        .waddr   (s1_dst),
        .wdata   (s1_data),
        .raddr_a (rt_src_a),
        .raddr_b (rt_src_b),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    rc_alu #(.XLEN(XLEN)) u_alu (
        .op (s1_op),
        .a  (s1_opa),
        .b  (s1_opb),
        .y  (recomp)
    );

    rc_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (s1_commit),
        .expire (wd_expire)
    );

    // Purpose: forward the value stage 1 is writing when stage 0 reads that register.
    always_comb begin
        arch_a = rf_a;
        arch_b = rf_b;
        if (s1_commit && (s1_dst != '0) && (s1_dst == rt_src_a))
            arch_a = s1_data;
        if (s1_commit && (s1_dst != '0) && (s1_dst == rt_src_b))
            arch_b = s1_data;
    end

    // Purpose: capture the request and its architected operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_op     <= '0;
            s1_dst    <= '0;
            s1_opa    <= '0;
            s1_opb    <= '0;
            s1_res    <= '0;
            s1_arch_a <= '0;
            s1_arch_b <= '0;
        end else begin
            s1_valid  <= rt_valid;
            s1_op     <= rt_op;
            s1_dst    <= rt_dst;
            s1_opa    <= rt_opnd_a;
            s1_opb    <= rt_opnd_b;
            s1_res    <= rt_result;
            s1_arch_a <= arch_a;
            s1_arch_b <= arch_b;
        end
    end

    // Purpose: run both verification paths and decide commit and faults.
    always_comb begin
        a_ok      = (s1_opa == s1_arch_a);
        b_ok      = (s1_op == OP_LDC) || (s1_opb == s1_arch_b);
        opnd_ok   = a_ok && b_ok;
        calc_ok   = (recomp == s1_res);
        s1_commit = s1_valid && opnd_ok;
        s1_fo     = s1_valid && !opnd_ok;
        s1_fc     = s1_valid && opnd_ok && !calc_ok;
        s1_data   = calc_ok ? s1_res : recomp;
    end

    // Purpose: register the outputs seen by the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit      <= 1'b0;
            commit_dst  <= '0;
            commit_data <= '0;
            fault_calc  <= 1'b0;
            fault_opnd  <= 1'b0;
            restart_req <= 1'b0;
        end else begin
            commit      <= s1_commit;
            commit_dst  <= s1_commit ? s1_dst : '0;
            commit_data <= s1_commit ? s1_data : '0;
            fault_calc  <= s1_fc;
            fault_opnd  <= s1_fo;
            restart_req <= s1_fc || s1_fo || wd_expire;
        end
    end
endmodule

// File: rtl/rc_checker_sva.sv
// Module: rc_checker_sva - port-level properties of retire_checker.
// Does: checks exclusivity of outcomes, restart coupling and request latency.
// Assumes: bound to every retire_checker instance; synchronous active-low reset.
module rc_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic rt_valid,
    input logic commit,
    input logic fault_calc,
    input logic fault_opnd,
    input logic restart_req,
    input logic [31:0] commit_data,
    input logic [3:0]  commit_dst
);
    logic v_d1, v_d2;

    // Purpose: remember whether a request was present one and two edges ago.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_d1 <= 1'b0;
            v_d2 <= 1'b0;
        end else begin
            v_d1 <= rt_valid;
            v_d2 <= v_d1;
        end
    end

    assert_opnd_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_opnd |-> !commit);
    assert_calc_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_calc |-> commit);
    assert_fault_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_calc || fault_opnd) |-> restart_req);
    assert_one_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fault_calc, fault_opnd}) <= 1);
    assert_out_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || fault_opnd) |-> v_d2);
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> (commit_data == '0 && commit_dst == '0));
    assert_timeout_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_req && !fault_calc && !fault_opnd) |-> !commit);
endmodule

bind retire_checker rc_checker_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rt_valid    (rt_valid),
    .commit      (commit),
    .fault_calc  (fault_calc),
    .fault_opnd  (fault_opnd),
    .restart_req (restart_req),
    .commit_data (commit_data),
    .commit_dst  (commit_dst)
);

// File: tb/retire_checker_tb.sv
module retire_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rt_valid = 1'b0;
    logic [2:0]  rt_op = '0;
    logic [3:0]  rt_src_a = '0, rt_src_b = '0, rt_dst = '0;
    logic [31:0] rt_opnd_a = '0, rt_opnd_b = '0, rt_result = '0;
    logic        commit, fault_calc, fault_opnd, restart_req;
    logic [3:0]  commit_dst;
    logic [31:0] commit_data;

    int checks = 0, failures = 0;
    int rs_count = 0;
    bit running = 1'b0;
    string phase = "R1";

    // issue-side program-order register shadow
    logic [31:0] sreg [16];
    // cycle model state
    logic [31:0] mreg [16];
    bit          p_valid;
    logic [2:0]  p_op;
    logic [3:0]  p_sa, p_sb, p_d;
    logic [31:0] p_a, p_b, p_r;
    int          wd_cnt;
    bit          e_commit, e_fc, e_fo, e_rs;
    logic [3:0]  e_dst;
    logic [31:0] e_data;

    always #5 clk = ~clk;

    retire_checker u_dut (
        .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_op(rt_op),
        .rt_src_a(rt_src_a), .rt_src_b(rt_src_b), .rt_dst(rt_dst),
        .rt_opnd_a(rt_opnd_a), .rt_opnd_b(rt_opnd_b), .rt_result(rt_result),
        .commit(commit), .commit_dst(commit_dst), .commit_data(commit_data),
        .fault_calc(fault_calc), .fault_opnd(fault_opnd), .restart_req(restart_req)
    );

    function automatic logic [31:0] f(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return b;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h (phase %s)", req, what, act, exp, phase);
        end
    endtask

    // behavioural cycle model: outputs after this edge
    always @(posedge clk) begin
        logic [31:0] xa, xb, rc;
        bit bad;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mreg[i] = '0;
            p_valid = 0; wd_cnt = 0;
            e_commit = 0; e_fc = 0; e_fo = 0; e_rs = 0; e_dst = '0; e_data = '0;
        end else begin
            e_commit = 0; e_fc = 0; e_fo = 0; e_rs = 0; e_dst = '0; e_data = '0;
            if (p_valid) begin
                xa = mreg[p_sa]; xb = mreg[p_sb];
                bad = (xa != p_a) || ((p_op != 3'd5) && (xb != p_b));
                rc = f(p_op, p_a, p_b);
                if (bad) begin
                    e_fo = 1; e_rs = 1;
                end else begin
                    e_commit = 1; e_dst = p_d;
                    e_data = (rc == p_r) ? p_r : rc;
                    if (rc != p_r) begin e_fc = 1; e_rs = 1; end
                    if (p_d != 0) mreg[p_d] = e_data;
                end
            end
            if (e_commit) wd_cnt = 0;
            else if (wd_cnt == 255) begin e_rs = 1; wd_cnt = 0; end
            else wd_cnt++;
        end
        p_valid = rst_n && rt_valid; p_op = rt_op; p_sa = rt_src_a; p_sb = rt_src_b;
        p_d = rt_dst; p_a = rt_opnd_a; p_b = rt_opnd_b; p_r = rt_result;
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (running) begin
            chk("R3", "commit", {31'd0, commit}, {31'd0, e_commit});
            chk("R3", "commit_dst", {28'd0, commit_dst}, {28'd0, e_dst});
            chk("R3", "commit_data", commit_data, e_data);
            chk("R5", "fault_calc", {31'd0, fault_calc}, {31'd0, e_fc});
            chk("R4", "fault_opnd", {31'd0, fault_opnd}, {31'd0, e_fo});
            chk("R8", "restart_req", {31'd0, restart_req}, {31'd0, e_rs});
            if (restart_req) rs_count++;
        end
    end

    task automatic issue(input logic [2:0] op, input logic [3:0] d, input logic [3:0] sa,
                         input logic [3:0] sb, input logic [31:0] imm,
                         input bit bad_a, input bit bad_b, input bit bad_r);
        logic [31:0] a, b;
        a = sreg[sa] ^ (bad_a ? 32'h0000_0010 : 32'h0);
        b = (op == 3'd5) ? imm : (sreg[sb] ^ (bad_b ? 32'h0000_0100 : 32'h0));
        rt_valid = 1; rt_op = op; rt_dst = d; rt_src_a = sa; rt_src_b = sb;
        rt_opnd_a = a; rt_opnd_b = b; rt_result = f(op, a, b) ^ (bad_r ? 32'h1 : 32'h0);
        if (!(bad_a || (bad_b && op != 3'd5)) && d != 0) sreg[d] = f(op, a, b);
        @(negedge clk);
        rt_valid = 0;
    endtask

    task automatic idle(input int n);
        rt_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed;
        for (int i = 0; i < 16; i++) sreg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "commit", {31'd0, commit}, 32'd0);
        chk("R1", "restart_req", {31'd0, restart_req}, 32'd0);
        chk("R1", "commit_data", commit_data, 32'd0);
        running = 1;
        // R1: registers read zero (correct zero operands accepted)
        phase = "R1";
        issue(3'd0, 4'd1, 4'd7, 4'd15, 0, 0, 0, 0);
        // R2 load constants into all registers, then each operation
        phase = "R2";
        for (int i = 1; i < 16; i++) issue(3'd5, 4'(i), 4'd0, 4'(i), 32'h1234_5000 + 32'(i * 97), 0, 0, 0);
        for (int op = 0; op < 8; op++) issue(3'(op), 4'd9, 4'(op + 1), 4'(op + 2), 0, 0, 0, 0);
        idle(2);
        // R6: back-to-back dependent chain through forwarding
        phase = "R6";
        issue(3'd0, 4'd3, 4'd1, 4'd2, 0, 0, 0, 0);
        issue(3'd1, 4'd4, 4'd3, 4'd3, 0, 0, 0, 0);
        issue(3'd4, 4'd4, 4'd4, 4'd3, 0, 0, 0, 0);
        // R7: write to register 0 reported, then register 0 read as zero
        phase = "R7";
        issue(3'd5, 4'd0, 4'd0, 4'd0, 32'hDEAD_BEEF, 0, 0, 0);
        issue(3'd3, 4'd5, 4'd0, 4'd0, 0, 0, 0, 0);
        issue(3'd3, 4'd5, 4'd0, 4'd6, 0, 1, 0, 0);
        // R4: bad operand drops the write; dependent reader sees old value
        phase = "R4";
        issue(3'd0, 4'd6, 4'd1, 4'd2, 0, 1, 0, 0);
        issue(3'd2, 4'd7, 4'd6, 4'd6, 0, 0, 0, 0);
        issue(3'd0, 4'd8, 4'd1, 4'd2, 0, 0, 1, 0);
        // R5: bad result is corrected and forwarded corrected
        phase = "R5";
        issue(3'd1, 4'd10, 4'd11, 4'd12, 0, 0, 0, 1);
        issue(3'd0, 4'd11, 4'd10, 4'd10, 0, 0, 0, 0);
        // R9: both faults at once
        phase = "R9";
        issue(3'd0, 4'd12, 4'd1, 4'd2, 0, 1, 0, 1);
        issue(3'd6, 4'd13, 4'd1, 4'd2, 0, 0, 0, 1);
        // R10: idle gap
        phase = "R10";
        idle(5);
        // R8: one pulse in 300 idle cycles after a commit
        phase = "R8";
        issue(3'd5, 4'd14, 4'd0, 4'd0, 32'h55, 0, 0, 0);
        rs_count = 0;
        idle(300);
        chk("R8", "timeout pulses", 32'(rs_count), 32'd1);
        rs_count = 0;
        for (int k = 0; k < 5; k++) begin
            issue(3'd4, 4'd14, 4'd14, 4'd1, 0, 0, 0, 0);
            idle(100);
        end
        chk("R8", "pulses with commits", 32'(rs_count), 32'd0);
        // mixed pseudo-random traffic
        phase = "R3";
        seed = 32'h1F2E3D;
        for (int k = 0; k < 300; k++) begin
            seed = seed * 1103515245 + 12345;
            issue(3'(seed >> 8), 4'(seed >> 12), 4'(seed >> 16), 4'(seed >> 20), 32'(seed),
                  ((seed >> 24) & 15) == 0, ((seed >> 24) & 15) == 1, ((seed >> 24) & 15) == 2);
            if (((seed >> 28) & 3) == 0) idle(1);
        end
        idle(4);
        running = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_500_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule